// File: doc/BRIEF.md
# Sleep-Entry Link Power Sequencer

This block sits on the downstream side of a serial point-to-point link and steps that link through the handshake that precedes system sleep. When every function of the component has been parked in D3hot, it asks for the link to drop from L0 to L1. A turn-off broadcast from upstream then forces the link back up to L0, because the acknowledge message can only travel on an active link. Once that acknowledge has fully left the transmitter, the block starts the L2/L3 Ready handshake and stays there until reset.

The link does not simply sink into deeper states. It runs L0, L1, back to L0, then L2/L3 Ready. Electrical idle, packet encoding and power switching are outside the block. Each link move is a request held high until the `link_done` input reports completion. Each message send is a request held high until `tx_done` reports completion. A turn-off that arrives while the link is still in L0 goes straight to the acknowledge. Leaving D3hot before the turn-off cancels the sequence and brings the link back to L0. A turn-off that arrives while an acknowledge is already owed sets a sticky error flag.

Top module: `sleep_seq`

## Requirements
- R1: After reset the controller is in L0 with `state_oh` = 7'b0000001, all four request outputs low, `link_state` = 2'b00 and `err_turnoff` low. The state bits are: 0 L0, 1 entering L1, 2 L1, 3 leaving L1, 4 sending ack, 5 entering L2/L3 Ready, 6 L2/L3 Ready.
- R2: In L0 with `dl_up` high, `all_d3hot` high and no turn-off, the next state is entering L1 and `req_l1` is high. On `link_done` it moves to L1. `link_state` reads 2'b01 in L1 and while leaving L1, 2'b10 in L2/L3 Ready, and 2'b00 in every other state.
- R3: In L1 a turn-off pulse moves to leaving L1 with `req_l0` high. On `link_done` it goes to sending ack, with `send_ack` high.
- R4: In L0 with `dl_up` high, a turn-off pulse goes directly to sending ack, even when `all_d3hot` is high.
- R5: `send_ack` stays high until `tx_done`. Only then does the block enter entering L2/L3 Ready, where `start_l23` stays high until `link_done` moves it to L2/L3 Ready.
- R6: L2/L3 Ready is left only through reset. No input combination changes it, and all request outputs stay low there.
- R7: Dropping `all_d3hot` before any turn-off cancels the sequence. From entering L1 the next state is L0. From L1 the next state is leaving L1, and `link_done` there returns the block to L0 instead of sending an ack.
- R8: A turn-off pulse while sending ack, or while leaving L1 after an earlier turn-off, sets `err_turnoff`, which stays set until reset. The state sequence is unaffected.
- R9: In L0 with `dl_up` low, neither `all_d3hot` nor a turn-off pulse leaves L0.
- R10: A turn-off pulse while entering L1 moves to leaving L1, and the following `link_done` leads to sending ack. Within that state a turn-off takes priority over a drop of `all_d3hot`, which takes priority over `link_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| all_d3hot | input | 1 | High while every function of the component is in D3hot |
| turnoff_pulse | input | 1 | One-cycle pulse per received turn-off broadcast |
| dl_up | input | 1 | Data link layer reports link up |
| link_done | input | 1 | Requested link transition has completed |
| tx_done | input | 1 | Acknowledge message fully transmitted |
| req_l1 | output | 1 | Request link move from L0 to L1 |
| req_l0 | output | 1 | Request link return from L1 to L0 |
| send_ack | output | 1 | Request transmission of the turn-off acknowledge |
| start_l23 | output | 1 | Request the L2/L3 Ready handshake |
| link_state | output | 2 | Current link state: 00 L0, 01 L1, 10 L2/L3 Ready |
| state_oh | output | 7 | One-hot controller state |
| err_turnoff | output | 1 | Sticky flag: turn-off while an acknowledge was already owed |

## Verification
The hardest cases to reach from the ports are the two versions of the leaving-L1 state. Both drive the same `req_l0`, but one owes an acknowledge and the other is a cancel, so they react differently to `link_done` and to a repeated turn-off. The bench resets and steers the block into each of eight starting configurations, including both leaving-L1 versions. From each one it applies all 32 combinations of the five inputs for one cycle and compares the whole output vector against an expectation derived from the requirements.

// File: rtl/sleep_seq.sv
module sleep_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       all_d3hot,
  input  logic       turnoff_pulse,
  input  logic       dl_up,
  input  logic       link_done,
  input  logic       tx_done,
  output logic       req_l1,
  output logic       req_l0,
  output logic       send_ack,
  output logic       start_l23,
  output logic [1:0] link_state,
  output logic [6:0] state_oh,
  output logic       err_turnoff
);

  localparam int NST = 7;
  localparam int B_L0 = 0, B_ENL1 = 1, B_L1 = 2, B_EXL1 = 3, B_ACK = 4, B_ENL23 = 5, B_L23 = 6;
  localparam logic [NST-1:0] S_L0    = NST'(1) << B_L0;
  localparam logic [NST-1:0] S_ENL1  = NST'(1) << B_ENL1;
  localparam logic [NST-1:0] S_L1    = NST'(1) << B_L1;
  localparam logic [NST-1:0] S_EXL1  = NST'(1) << B_EXL1;
  localparam logic [NST-1:0] S_ACK   = NST'(1) << B_ACK;
  localparam logic [NST-1:0] S_ENL23 = NST'(1) << B_ENL23;
  localparam logic [NST-1:0] S_L23   = NST'(1) << B_L23;

  logic [NST-1:0] st, st_nx;
  logic owed, owed_nx;
  logic err;
  logic bad_to;

  always_comb begin
    st_nx   = st;
    owed_nx = owed;
    unique case (1'b1)
      st[B_L0]: begin
        owed_nx = 1'b0;
        if (dl_up && turnoff_pulse)  st_nx = S_ACK;
        else if (dl_up && all_d3hot) st_nx = S_ENL1;
      end
      st[B_ENL1]: begin
        if (turnoff_pulse) begin
          st_nx   = S_EXL1;
          owed_nx = 1'b1;
        end else if (!all_d3hot) st_nx = S_L0;
        else if (link_done)      st_nx = S_L1;
      end
      st[B_L1]: begin
        if (turnoff_pulse) begin
          st_nx   = S_EXL1;
          owed_nx = 1'b1;
        end else if (!all_d3hot) begin
          st_nx   = S_EXL1;
          owed_nx = 1'b0;
        end
      end
      st[B_EXL1]: begin
        if (turnoff_pulse) owed_nx = 1'b1;
        if (link_done) st_nx = (owed || turnoff_pulse) ? S_ACK : S_L0;
      end
      st[B_ACK]:   if (tx_done)   st_nx = S_ENL23;
      st[B_ENL23]: if (link_done) st_nx = S_L23;
      st[B_L23]:   st_nx = S_L23;
      default:     st_nx = S_L0;
    endcase
  end

  assign bad_to = turnoff_pulse && (st[B_ACK] || (st[B_EXL1] && owed));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_L0;
      owed <= 1'b0;
      err  <= 1'b0;
    end else begin
      st   <= st_nx;
      owed <= owed_nx;
      if (bad_to) err <= 1'b1;
    end
  end

  assign req_l1      = st[B_ENL1];
  assign req_l0      = st[B_EXL1];
  assign send_ack    = st[B_ACK];
  assign start_l23   = st[B_ENL23];
  assign link_state  = (st[B_L1] || st[B_EXL1]) ? 2'b01 : (st[B_L23] ? 2'b10 : 2'b00);
  assign state_oh    = st;
  assign err_turnoff = err;

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_oh)); // R1
  AST_L1_FROM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_oh[B_L1]) |-> $past(req_l1 && link_done && all_d3hot)); // R2
  AST_ACK_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_ack) |-> $past((st[B_L0] && turnoff_pulse && dl_up) || (req_l0 && link_done))); // R4
  AST_ACK_DONE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_l23) |-> $past(send_ack && tx_done)); // R5
  AST_L23_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_oh[B_L23]) |-> $past(start_l23 && link_done)); // R5
  AST_L23_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[B_L23] |=> state_oh[B_L23]); // R6
  AST_CANCEL_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[B_L1] && !all_d3hot && !turnoff_pulse) |=> (req_l0 && !owed)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_turnoff |=> err_turnoff); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_turnoff) |-> $past(turnoff_pulse && (send_ack || req_l0))); // R8
  AST_LINK_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[B_L0] && !dl_up) |=> state_oh[B_L0]); // R9

endmodule

// File: tb/test_sleep_seq.sv
`timescale 1ns/1ps
module test_sleep_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic d3 = 0, to = 0, up = 0, ld = 0, td = 0;
  logic req_l1, req_l0, send_ack, start_l23, err_turnoff;
  logic [1:0] link_state;
  logic [6:0] state_oh;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sleep_seq i_sleep_seq (
    .clk(clk), .rst_n(rst_n), .all_d3hot(d3), .turnoff_pulse(to), .dl_up(up),
    .link_done(ld), .tx_done(td), .req_l1(req_l1), .req_l0(req_l0),
    .send_ack(send_ack), .start_l23(start_l23), .link_state(link_state),
    .state_oh(state_oh), .err_turnoff(err_turnoff));

  // bench state indices follow the bit positions listed in R1
  function automatic logic [13:0] expv(int s, logic e);
    logic [1:0] ls;
    ls = (s == 2 || s == 3) ? 2'b01 : (s == 6 ? 2'b10 : 2'b00);
    return {7'(1) << s, s == 1, s == 3, s == 4, s == 5, ls, e};
  endfunction

  function automatic logic [13:0] actv();
    return {state_oh, req_l1, req_l0, send_ack, start_l23, link_state, err_turnoff};
  endfunction

  task automatic check(string tag, logic [13:0] exp);
    checks++;
    if (actv() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, actv(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(logic a, logic b, logic c, logic d, logic e);
    d3 = a; to = b; up = c; ld = d; td = e;
  endtask

  task automatic do_reset();
    rst_n = 0;
    set_in(0, 0, 0, 0, 0);
    step();
    step();
    rst_n = 1;
  endtask

  // cfg: 0 L0, 1 entering L1, 2 L1, 3 leaving L1 owed, 4 leaving L1 cancel,
  //      5 sending ack, 6 entering L2/L3, 7 L2/L3 Ready
  task automatic prep(int cfg);
    do_reset();
    if (cfg >= 1 && cfg <= 4) begin set_in(1, 0, 1, 0, 0); step(); end
    if (cfg >= 2 && cfg <= 4) begin set_in(1, 0, 1, 1, 0); step(); end
    if (cfg == 3) begin set_in(1, 1, 1, 0, 0); step(); end
    if (cfg == 4) begin set_in(0, 0, 1, 0, 0); step(); end
    if (cfg >= 5) begin set_in(0, 1, 1, 0, 0); step(); end
    if (cfg >= 6) begin set_in(0, 0, 1, 0, 1); step(); end
    if (cfg == 7) begin set_in(0, 0, 1, 1, 0); step(); end
  endtask

  function automatic int cfg_state(int cfg);
    case (cfg)
      0: return 0; 1: return 1; 2: return 2; 3: return 3; 4: return 3;
      5: return 4; 6: return 5; default: return 6;
    endcase
  endfunction

  function automatic int nxt(int cfg, logic a, logic b, logic c, logic d, logic e);
    case (cfg)
      0: return (c && b) ? 4 : ((c && a) ? 1 : 0);
      1: return b ? 3 : (!a ? 0 : (d ? 2 : 1));
      2: return (b || !a) ? 3 : 2;
      3: return d ? 4 : 3;
      4: return d ? (b ? 4 : 0) : 3;
      5: return e ? 5 : 4;
      6: return d ? 6 : 5;
      default: return 6;
    endcase
  endfunction

  function automatic string tag_of(int cfg);
    case (cfg)
      0: return "R2 R4 R9";
      1: return "R7 R10";
      2: return "R3 R7";
      3: return "R3 R8";
      4: return "R7";
      5: return "R5 R8";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset", expv(0, 0));

    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int v = 0; v < 32; v++) begin
        logic a, b, c, d, e, ex;
        prep(cfg);
        check({tag_of(cfg), " prep"}, expv(cfg_state(cfg), 0));
        {e, d, c, b, a} = 5'(v);
        ex = b && (cfg == 3 || cfg == 5);
        set_in(a, b, c, d, e);
        step();
        set_in(0, 0, 0, 0, 0);
        check(tag_of(cfg), expv(nxt(cfg, a, b, c, d, e), ex));
      end
    end

    // R5 full path L0 -> L1 -> L0 -> L2/L3 Ready with stall cycles
    do_reset();
    set_in(1, 0, 1, 0, 0); step(); check("R2 request L1", expv(1, 0));
    set_in(1, 0, 1, 0, 0); step(); check("R2 hold request", expv(1, 0));
    set_in(1, 0, 1, 1, 0); step(); check("R2 in L1", expv(2, 0));
    set_in(1, 1, 1, 0, 0); step(); check("R3 leave L1", expv(3, 0));
    set_in(1, 0, 1, 1, 0); step(); check("R3 ack", expv(4, 0));
    for (int k = 0; k < 3; k++) begin
      set_in(1, 0, 1, 1, 0); step(); check("R5 ack held", expv(4, 0));
    end
    set_in(1, 0, 1, 0, 1); step(); check("R5 start L23", expv(5, 0));
    set_in(1, 0, 1, 0, 1); step(); check("R5 start held", expv(5, 0));
    set_in(1, 0, 1, 1, 0); step(); check("R5 in L23", expv(6, 0));
    for (int k = 0; k < 64; k++) begin
      set_in(k[0], k[1], k[2], k[3], k[4]); step();
      check("R6 sticky L23", expv(6, 0));
    end

    // R8 error survives the rest of the flow
    do_reset();
    set_in(0, 1, 1, 0, 0); step();
    set_in(0, 1, 1, 0, 0); step(); check("R8 error set", expv(4, 1));
    set_in(0, 0, 1, 0, 1); step(); check("R8 error kept", expv(5, 1));
    set_in(0, 0, 1, 1, 0); step(); check("R8 error in L23", expv(6, 1));
    do_reset(); check("R1 reset clears", expv(0, 0));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule